// File: doc/BRIEF.md
# Aligned Burst Transaction Splitter

This block takes one packed transfer job (a source address, a destination address and a length in bytes) and cuts it into two independent command streams for a 64-bit port: one for the read side and one for the write side. Each command carries a start address, a size code, a beat count and a flag that marks a burst. Where the address is aligned, the block issues full bursts of the burst size set for that side. Before the first burst boundary and after the last one, it issues smaller power-of-two transactions.

Each side has its own burst size setting (16, 32 or 64 bytes) and its own burst-permit input. The permit is raised when that side is packed or uses constant addressing. When the permit is low, that side only gets single accesses of 8 bytes or less. The job port and both command ports use valid/ready. The job is taken only when both command streams have drained. A command stays on its port, unchanged, until the port's ready is seen high at a clock edge. Back-pressure on one side never stalls the other side. The configuration inputs are plain pins and are sampled in the cycle the job is accepted.

Top module: `burst_splitter`

## Requirements
- R1: `job_ready` is high exactly when neither side has a command pending. A job is accepted on a clock edge with `job_valid` and `job_ready` both high.
- R2: A job of length 0 is accepted and produces no command on either side.
- R3: The transaction size of every command is 2^`cmd_lg` bytes, and its address is a multiple of that size. As a result, no command crosses a burst boundary.
- R4: The burst size code is 0 for 16 bytes, 1 for 32 bytes, and 2 or 3 for 64 bytes. With the permit high, no command of that side is larger than the side's burst size.
- R5: With a side's permit low, every command of that side has `cmd_lg` of 3 or less, one beat, and the burst flag low.
- R6: Each command uses the largest power-of-two size that meets all of these conditions: it is at most the remaining bytes, it is allowed by R4/R5, and it is satisfied by the address alignment.
- R7: The beat count is 2^(`cmd_lg`-3), with a minimum of 1. The burst flag is high exactly when the beat count is more than 1.
- R8: The commands of one side cover the range from the side's start address to start+length-1 contiguously, in increasing address order, with no gap and no overlap.
- R9: A command is consumed only on a clock edge where its valid and ready are both high. While valid is high and ready is low, the command is held stable.
- R10: The read side uses `rd_bsize`/`rd_burst_ok` and the source address. The write side uses `wr_bsize`/`wr_burst_ok` and the destination address. The two streams advance independently.
- R11: Configuration inputs are captured when the job is accepted. Changes to them while the job is in progress have no effect on its commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Job can be accepted (both sides idle) |
| job_src_addr | input | ADDR_W | Read-side start byte address |
| job_dst_addr | input | ADDR_W | Write-side start byte address |
| job_len | input | LEN_W | Transfer length in bytes |
| rd_bsize | input | 2 | Read burst size code |
| rd_burst_ok | input | 1 | Read side may burst (packed or constant addressing) |
| wr_bsize | input | 2 | Write burst size code |
| wr_burst_ok | input | 1 | Write side may burst |
| rd_cmd_valid | output | 1 | Read command valid |
| rd_cmd_ready | input | 1 | Read command accepted |
| rd_cmd_addr | output | ADDR_W | Read command start address |
| rd_cmd_lg | output | 3 | Read transaction size, log2 bytes |
| rd_cmd_beats | output | 4 | Read beat count |
| rd_cmd_burst | output | 1 | Read command is a burst |
| wr_cmd_valid | output | 1 | Write command valid |
| wr_cmd_ready | input | 1 | Write command accepted |
| wr_cmd_addr | output | ADDR_W | Write command start address |
| wr_cmd_lg | output | 3 | Write transaction size, log2 bytes |
| wr_cmd_beats | output | 4 | Write beat count |
| wr_cmd_burst | output | 1 | Write command is a burst |

## Verification
The assertions check these properties on every cycle for both sides:
- Address alignment to the transaction size.
- The agreement between beat count, size and burst flag.
- That commands hold still under back-pressure.
- That a job is never accepted while commands are pending.
- That each command starts exactly where the previous one ended.

Some properties need knowledge of the whole job, so only the bench scenarios can show them:
- The greedy size choice.
- Respect for each side's size cap and permit.
- Coverage of the full length.
- Capture of the configuration at acceptance.

The bench covers these with directed unaligned heads and tails, zero and maximum lengths, and random jobs with configuration churn.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int MAX_LG  = 6;   // 64-byte ceiling
  localparam int BEAT_LG = 3;   // 8-byte port
  localparam int LG_W    = 3;
  localparam int BEATS_W = 4;

  typedef logic [LG_W-1:0] lg_t;

  // Largest permitted transaction (log2 bytes) for one side
  function automatic lg_t cap_lg(input logic [1:0] bsize, input logic burst_ok);
    if (!burst_ok)        return lg_t'(BEAT_LG);
    else if (bsize >= 2)  return lg_t'(MAX_LG);
    else                  return lg_t'(4 + int'(bsize));
  endfunction

  function automatic logic [BEATS_W-1:0] beats_of(input lg_t lg);
    if (lg <= lg_t'(BEAT_LG)) return BEATS_W'(1);
    return BEATS_W'(1) << (lg - lg_t'(BEAT_LG));
  endfunction
endpackage

// File: rtl/bsplit_size_sel.sv
module bsplit_size_sel
  import bsplit_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [MAX_LG-1:0] addr_lo,
  input  logic [LEN_W-1:0]  remain,
  input  lg_t               cap,
  output lg_t               lg
);
  // Pick the largest size that fits the remainder, the alignment and the cap
  always_comb begin
    lg = '0;
    for (int i = 1; i <= MAX_LG; i++) begin
      if ((i <= int'(cap)) &&
          (remain >= (LEN_W'(1) << i)) &&
          ((int'(addr_lo) & ((1 << i) - 1)) == 0))
        lg = lg_t'(i);
    end
  end
endmodule

// File: rtl/bsplit_engine.sv
module bsplit_engine
  import bsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [LEN_W-1:0]   ld_len,
  input  logic [1:0]         ld_bsize,
  input  logic               ld_burst_ok,
  output logic               busy,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADDR_W-1:0]  cmd_addr,
  output lg_t                cmd_lg,
  output logic [BEATS_W-1:0] cmd_beats,
  output logic               cmd_burst
);
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  lg_t               cap_q;
  lg_t               lg;
  logic [LEN_W-1:0]  step;
  logic              fire;

  bsplit_size_sel #(.LEN_W(LEN_W)) u_sel (
    .addr_lo (cur_addr[MAX_LG-1:0]),
    .remain  (remain),
    .cap     (cap_q),
    .lg      (lg)
  );

  assign step = LEN_W'(1) << lg;
  assign fire = busy && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      cap_q    <= '0;
    end else if (load) begin
      busy     <= (ld_len != '0);
      cur_addr <= ld_addr;
      remain   <= ld_len;
      cap_q    <= cap_lg(ld_bsize, ld_burst_ok);
    end else if (fire) begin
      cur_addr <= cur_addr + ADDR_W'(step);
      remain   <= remain - step;
      if (remain == step) busy <= 1'b0;
    end
  end

  assign cmd_valid = busy;
  assign cmd_addr  = cur_addr;
  assign cmd_lg    = lg;
  assign cmd_beats = beats_of(lg);
  assign cmd_burst = (lg > lg_t'(BEAT_LG));
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
  import bsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               job_valid,
  output logic               job_ready,
  input  logic [ADDR_W-1:0]  job_src_addr,
  input  logic [ADDR_W-1:0]  job_dst_addr,
  input  logic [LEN_W-1:0]   job_len,
  input  logic [1:0]         rd_bsize,
  input  logic               rd_burst_ok,
  input  logic [1:0]         wr_bsize,
  input  logic               wr_burst_ok,
  output logic               rd_cmd_valid,
  input  logic               rd_cmd_ready,
  output logic [ADDR_W-1:0]  rd_cmd_addr,
  output logic [2:0]         rd_cmd_lg,
  output logic [3:0]         rd_cmd_beats,
  output logic               rd_cmd_burst,
  output logic               wr_cmd_valid,
  input  logic               wr_cmd_ready,
  output logic [ADDR_W-1:0]  wr_cmd_addr,
  output logic [2:0]         wr_cmd_lg,
  output logic [3:0]         wr_cmd_beats,
  output logic               wr_cmd_burst
);
  logic rd_busy, wr_busy, load;

  assign job_ready = !rd_busy && !wr_busy;
  assign load      = job_valid && job_ready;

  bsplit_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_addr(job_src_addr), .ld_len(job_len),
    .ld_bsize(rd_bsize), .ld_burst_ok(rd_burst_ok),
    .busy(rd_busy),
    .cmd_valid(rd_cmd_valid), .cmd_ready(rd_cmd_ready),
    .cmd_addr(rd_cmd_addr), .cmd_lg(rd_cmd_lg),
    .cmd_beats(rd_cmd_beats), .cmd_burst(rd_cmd_burst)
  );

  bsplit_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_addr(job_dst_addr), .ld_len(job_len),
    .ld_bsize(wr_bsize), .ld_burst_ok(wr_burst_ok),
    .busy(wr_busy),
    .cmd_valid(wr_cmd_valid), .cmd_ready(wr_cmd_ready),
    .cmd_addr(wr_cmd_addr), .cmd_lg(wr_cmd_lg),
    .cmd_beats(wr_cmd_beats), .cmd_burst(wr_cmd_burst)
  );
endmodule

// File: rtl/bsplit_checker.sv
module bsplit_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              job_valid,
  input logic              job_ready,
  input logic [ADDR_W-1:0] job_src_addr,
  input logic [ADDR_W-1:0] job_dst_addr,
  input logic              rd_cmd_valid,
  input logic              rd_cmd_ready,
  input logic [ADDR_W-1:0] rd_cmd_addr,
  input logic [2:0]        rd_cmd_lg,
  input logic [3:0]        rd_cmd_beats,
  input logic              rd_cmd_burst,
  input logic              wr_cmd_valid,
  input logic              wr_cmd_ready,
  input logic [ADDR_W-1:0] wr_cmd_addr,
  input logic [2:0]        wr_cmd_lg,
  input logic [3:0]        wr_cmd_beats,
  input logic              wr_cmd_burst
);
  logic [ADDR_W-1:0] rd_next, wr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_next <= '0;
      wr_next <= '0;
    end else begin
      if (job_valid && job_ready) begin
        rd_next <= job_src_addr;
        wr_next <= job_dst_addr;
      end
      if (rd_cmd_valid && rd_cmd_ready) rd_next <= rd_cmd_addr + (ADDR_W'(1) << rd_cmd_lg);
      if (wr_cmd_valid && wr_cmd_ready) wr_next <= wr_cmd_addr + (ADDR_W'(1) << wr_cmd_lg);
    end
  end

  AST_JOB_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd_valid || wr_cmd_valid) |-> !job_ready); // R1
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> ((rd_cmd_addr & ((ADDR_W'(1) << rd_cmd_lg) - ADDR_W'(1))) == '0)); // R3
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> ((wr_cmd_addr & ((ADDR_W'(1) << wr_cmd_lg) - ADDR_W'(1))) == '0)); // R3
  AST_RD_LG_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> (rd_cmd_lg <= 3'd6)); // R4
  AST_WR_LG_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> (wr_cmd_lg <= 3'd6)); // R4
  AST_RD_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> ((rd_cmd_burst == (rd_cmd_beats > 4'd1)) &&
                      ((rd_cmd_lg > 3'd3) ? (rd_cmd_beats == (4'd1 << (rd_cmd_lg - 3'd3))) : (rd_cmd_beats == 4'd1)))); // R7
  AST_WR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> ((wr_cmd_burst == (wr_cmd_beats > 4'd1)) &&
                      ((wr_cmd_lg > 3'd3) ? (wr_cmd_beats == (4'd1 << (wr_cmd_lg - 3'd3))) : (wr_cmd_beats == 4'd1)))); // R7
  AST_RD_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> (rd_cmd_addr == rd_next)); // R8
  AST_WR_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> (wr_cmd_addr == wr_next)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd_valid && !rd_cmd_ready) |=> (rd_cmd_valid && $stable(rd_cmd_addr) && $stable(rd_cmd_lg))); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_valid && !wr_cmd_ready) |=> (wr_cmd_valid && $stable(wr_cmd_addr) && $stable(wr_cmd_lg))); // R9
endmodule

bind burst_splitter bsplit_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bsplit_chk (
  .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
  .job_src_addr(job_src_addr), .job_dst_addr(job_dst_addr),
  .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
  .rd_cmd_lg(rd_cmd_lg), .rd_cmd_beats(rd_cmd_beats), .rd_cmd_burst(rd_cmd_burst),
  .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr),
  .wr_cmd_lg(wr_cmd_lg), .wr_cmd_beats(wr_cmd_beats), .wr_cmd_burst(wr_cmd_burst)
);

// File: tb/test_burst_splitter.sv
module test_burst_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        job_valid = 1'b0;
  logic        job_ready;
  logic [31:0] job_src_addr = '0, job_dst_addr = '0;
  logic [15:0] job_len = '0;
  logic [1:0]  rd_bsize = '0, wr_bsize = '0;
  logic        rd_burst_ok = 1'b0, wr_burst_ok = 1'b0;
  logic        rd_cmd_valid, wr_cmd_valid;
  logic        rd_cmd_ready = 1'b0, wr_cmd_ready = 1'b0;
  logic [31:0] rd_cmd_addr, wr_cmd_addr;
  logic [2:0]  rd_cmd_lg, wr_cmd_lg;
  logic [3:0]  rd_cmd_beats, wr_cmd_beats;
  logic        rd_cmd_burst, wr_cmd_burst;

  always #2 clk = ~clk;  // 250 MHz

  burst_splitter i_burst_splitter (.*);

  typedef struct { logic [31:0] a; int lg; int cap; } ent_t;
  typedef struct { logic [31:0] s; logic [31:0] d; int len; } job_t;

  ent_t rq[$], wq[$];
  job_t jobs[$];
  int   checks = 0, failures = 0, cycles = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural split: descend from the cap until the size fits and is aligned
  task automatic expand(input logic [31:0] a0, input int len, input logic [1:0] bs,
                        input bit ok, inout ent_t q[$]);
    logic [31:0] a = a0;
    int r = len;
    int cap = !ok ? 3 : (bs >= 2 ? 6 : 4 + bs);
    while (r > 0) begin
      int lg = cap;
      while ((1 << lg) > r || (a % (1 << lg)) != 0) lg--;
      q.push_back('{a: a, lg: lg, cap: cap});
      a += 32'(1 << lg);
      r -= (1 << lg);
    end
  endtask

  task automatic compare_side(input string nm, inout ent_t q[$], input logic v,
                              input logic [31:0] a, input logic [2:0] lg,
                              input logic [3:0] bt, input logic bu, input logic rdy);
    chk(v == (q.size() != 0), "R9", {nm, " valid"}, v, q.size() != 0);
    if (v && q.size() != 0) begin
      int elg = q[0].lg;
      int ebt = elg > 3 ? (1 << (elg - 3)) : 1;
      chk(a == q[0].a, "R8", {nm, " addr"}, a, q[0].a);
      chk(int'(lg) == elg, "R6", {nm, " size"}, lg, elg);
      chk(int'(lg) <= q[0].cap, "R4 R5 R11", {nm, " size cap"}, lg, q[0].cap);
      chk((a & ((32'(1) << lg) - 1)) == 0, "R3", {nm, " alignment"}, a, 0);
      chk(int'(bt) == ebt, "R7", {nm, " beats"}, bt, ebt);
      chk(bu == (ebt > 1), "R7", {nm, " burst flag"}, bu, ebt > 1);
      if (rdy) void'(q.pop_front());
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int jobs_left;
    // Directed jobs: aligned, unaligned head, 1 byte, zero, unaligned head+tail, maximum
    jobs.push_back('{s: 32'h100, d: 32'h2000, len: 256});
    jobs.push_back('{s: 32'h3, d: 32'h2C, len: 200});
    jobs.push_back('{s: 32'h7, d: 32'h9, len: 1});
    jobs.push_back('{s: 32'h40, d: 32'h80, len: 0});
    jobs.push_back('{s: 32'h1F8, d: 32'h1F0, len: 32'h48});
    jobs.push_back('{s: 32'h1000, d: 32'h3005, len: 65535});
    jobs_left = 400;

    repeat (3) @(negedge clk);
    chk(job_ready == 1'b1, "R1", "reset job_ready", job_ready, 1);
    chk(rd_cmd_valid == 1'b0 && wr_cmd_valid == 1'b0, "R9", "reset valids", rd_cmd_valid, 0);
    rst_n = 1'b1;

    // R2: zero-length job accepted with no commands following
    @(negedge clk);
    job_valid = 1'b1; job_len = '0; job_src_addr = 32'h11; job_dst_addr = 32'h23;
    #1;
    chk(job_ready == 1'b1, "R2", "zero job ready", job_ready, 1);
    @(negedge clk);
    job_valid = 1'b0;
    #1;
    chk(!rd_cmd_valid && !wr_cmd_valid && job_ready, "R2", "zero job no cmd",
        {rd_cmd_valid, wr_cmd_valid, job_ready}, 3'b001);

    while (!done) begin
      @(negedge clk);
      // Ready patterns: stalls, and R10 independent per side
      rd_cmd_ready = ($urandom % 4) != 0;
      wr_cmd_ready = ($urandom % 3) == 0;
      // R11: config churns every cycle; only the value at acceptance counts
      rd_bsize = 2'($urandom); wr_bsize = 2'($urandom);
      rd_burst_ok = ($urandom % 4) != 0; wr_burst_ok = ($urandom % 4) != 0;
      if (jobs.size() == 0 && jobs_left > 0) begin
        int l = ($urandom % 10 == 0) ? 0 : int'($urandom % 300);
        jobs.push_back('{s: $urandom, d: $urandom, len: l});
        jobs_left--;
      end
      if (jobs.size() != 0) begin
        job_valid = ($urandom % 4) != 0;
        job_src_addr = jobs[0].s; job_dst_addr = jobs[0].d; job_len = 16'(jobs[0].len);
      end else job_valid = 1'b0;
      #1;
      chk(job_ready == (rq.size() == 0 && wq.size() == 0), "R1", "job_ready",
          job_ready, rq.size() == 0 && wq.size() == 0);
      compare_side("rd R10", rq, rd_cmd_valid, rd_cmd_addr, rd_cmd_lg, rd_cmd_beats, rd_cmd_burst, rd_cmd_ready);
      compare_side("wr R10", wq, wr_cmd_valid, wr_cmd_addr, wr_cmd_lg, wr_cmd_beats, wr_cmd_burst, wr_cmd_ready);
      if (job_valid && job_ready) begin
        expand(jobs[0].s, jobs[0].len, rd_bsize, rd_burst_ok, rq);
        expand(jobs[0].d, jobs[0].len, wr_bsize, wr_burst_ok, wq);
        void'(jobs.pop_front());
      end
      if (jobs_left == 0 && jobs.size() == 0 && rq.size() == 0 && wq.size() == 0) begin
        @(negedge clk);
        #1;
        chk(job_ready && !rd_cmd_valid && !wr_cmd_valid, "R8", "drained at end",
            {job_ready, rd_cmd_valid, wr_cmd_valid}, 3'b100);
        done = 1;
      end
    end
    finish_run();
  end
endmodule